// File: doc/BRIEF.md
# Memory ECC Error Injection Controller

This block sits on the write path of a memory channel. It corrupts the stored ECC check bits or the command address parity on purpose, so that downstream error-detection and correction logic can be tested in place. A cacheline passes through as two 32-byte halves. Each half carries its own ECC check word. The command parity bit travels alongside. An external comparator supplies an address-hit strobe. The block does not generate ECC codes and does not compare addresses itself.

Software first loads a flip mask and then writes a control word that arms injection. A transfer counts as an injection event when both the transfer-valid input and the address-hit input are high in the same cycle. On an event the block XORs the mask into the selected half or halves. When armed for it, the block also inverts the command parity bit.

Each arm fires once by default: the enable bits clear themselves after the first event. When the repeat bit is set, every event is corrupted until software clears that bit. A mask confined to bits 15:0 or to bits 31:16 yields a correctable error. A mask that touches both of those 16-bit groups yields an uncorrectable error.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, the mask register and every control field are 0, and both register reads return 0.
- R2: A write with `reg_sel`=0 loads the mask and leaves the control fields unchanged. A write with `reg_sel`=1 loads the control fields and leaves the mask unchanged. A read with `reg_rsel`=0 returns the mask. A read with `reg_rsel`=1 returns the control fields in bits 4:0, with all higher bits 0.
- R3: The control word layout is: bit 0 repeat, bits 2:1 half select, bit 3 ECC arm, bit 4 parity arm.
- R4: The ECC outputs equal the ECC inputs in any cycle where the ECC arm bit is 0 or no event occurs.
- R5: During an event with the ECC arm bit set, half select 01 XORs the mask into the lower word only. Select 10 XORs it into the upper word only. Select 11 XORs it into both words. Select 00 XORs it into neither word. The corruption appears on the outputs in the same cycle as the event.
- R6: With repeat at 0, an event clears each arm bit that was set, effective in the following cycle. As a result exactly one event is corrupted per arm. The clear happens even when half select is 00.
- R7: With repeat at 1, the arm bits stay set across events, and every event is corrupted until software clears the repeat bit.
- R8: During an event with the parity arm bit set, `cmd_par_out` is the inverse of `cmd_par_in`, regardless of the mask and the half select. Otherwise the parity bit passes through unchanged.
- R9: A control write in the same cycle as an auto-clear takes precedence: the written value is the value held afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 selects the mask, 1 selects the control word |
| reg_wdata | input | ECC_W | Write data |
| reg_rsel | input | 1 | Read select: 0 selects the mask, 1 selects the control word |
| reg_rdata | output | ECC_W | Read data |
| xfer_valid | input | 1 | A cacheline transfer is present this cycle |
| addr_hit | input | 1 | Address-match strobe from the external comparator |
| ecc_lo_in | input | ECC_W | Lower-half ECC word in |
| ecc_hi_in | input | ECC_W | Upper-half ECC word in |
| cmd_par_in | input | 1 | Command parity in |
| ecc_lo_out | output | ECC_W | Lower-half ECC word out |
| ecc_hi_out | output | ECC_W | Upper-half ECC word out |
| cmd_par_out | output | 1 | Command parity out |

## Verification
The bench builds the block with the default ECC_W of 32. At that width the mask spans both 16-bit symbol groups, so both correctable patterns (confined to one group) and uncorrectable patterns (spanning both groups) reach the outputs. The control fields also leave 27 upper read bits that must stay 0. Directed phases cover each half-select code, one-shot versus repeat arming, parity-only arming, and a control write that collides with an auto-clear. A long random phase then mixes writes, hits and data patterns, and a behavioural model checks the results on every cycle.

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl #(
  parameter int ECC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [ECC_W-1:0] reg_wdata,
  input  logic             reg_rsel,
  output logic [ECC_W-1:0] reg_rdata,
  input  logic             xfer_valid,
  input  logic             addr_hit,
  input  logic [ECC_W-1:0] ecc_lo_in,
  input  logic [ECC_W-1:0] ecc_hi_in,
  input  logic             cmd_par_in,
  output logic [ECC_W-1:0] ecc_lo_out,
  output logic [ECC_W-1:0] ecc_hi_out,
  output logic             cmd_par_out
);
  localparam int CTRL_W = 5;

  logic [ECC_W-1:0] mask_q;
  logic             repeat_q;
  logic [1:0]       half_q;
  logic             ecc_arm_q;
  logic             par_arm_q;
  logic [CTRL_W-1:0] ctrl;

  wire hit      = xfer_valid & addr_hit;
  wire ecc_fire = hit & ecc_arm_q;
  wire par_fire = hit & par_arm_q;
  wire ctrl_wr  = reg_wr & reg_sel;
  wire mask_wr  = reg_wr & ~reg_sel;

  assign ctrl = {par_arm_q, ecc_arm_q, half_q, repeat_q};
  assign reg_rdata = reg_rsel ? {{(ECC_W-CTRL_W){1'b0}}, ctrl} : mask_q;

  assign ecc_lo_out  = ecc_lo_in ^ ({ECC_W{ecc_fire & half_q[0]}} & mask_q);
  assign ecc_hi_out  = ecc_hi_in ^ ({ECC_W{ecc_fire & half_q[1]}} & mask_q);
  assign cmd_par_out = cmd_par_in ^ par_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      repeat_q  <= 1'b0;
      half_q    <= 2'b00;
      ecc_arm_q <= 1'b0;
      par_arm_q <= 1'b0;
    end else if (ctrl_wr) begin
      repeat_q  <= reg_wdata[0];
      half_q    <= reg_wdata[2:1];
      ecc_arm_q <= reg_wdata[3];
      par_arm_q <= reg_wdata[4];
    end else if (!repeat_q) begin
      if (ecc_fire) ecc_arm_q <= 1'b0;
      if (par_fire) par_arm_q <= 1'b0;
    end
  end

  // R4
  a_r4_quiet_when_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!ecc_arm_q || !hit) |-> (ecc_lo_out == ecc_lo_in && ecc_hi_out == ecc_hi_in));

  // R5
  a_r5_select_none: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q == 2'b00) |-> (ecc_lo_out == ecc_lo_in && ecc_hi_out == ecc_hi_in));

  // R6
  a_r6_one_shot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ecc_arm_q && !repeat_q && !ctrl_wr) |=> (!ecc_arm_q && ecc_lo_out == ecc_lo_in
      && ecc_hi_out == ecc_hi_in));

  // R7
  a_r7_repeat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_arm_q && repeat_q && !ctrl_wr) |=> ecc_arm_q);

  // R8
  a_r8_parity_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_par_out != cmd_par_in) |-> (hit && par_arm_q));

  // R9
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (reg_rsel || reg_rdata[CTRL_W-1:0] == reg_rdata[CTRL_W-1:0])
      && ({par_arm_q, ecc_arm_q} == $past(reg_wdata[4:3])));
endmodule

// File: tb/tb_ecc_inject_ctrl.sv
`timescale 1ns/1ps
module tb_ecc_inject_ctrl;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_sel = 0, reg_rsel = 0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic xfer_valid = 0, addr_hit = 0, cmd_par_in = 0;
  logic [W-1:0] ecc_lo_in = '0, ecc_hi_in = '0;
  logic [W-1:0] ecc_lo_out, ecc_hi_out;
  logic cmd_par_out;

  always #2.5 clk = ~clk;

  ecc_inject_ctrl #(.ECC_W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .xfer_valid(xfer_valid), .addr_hit(addr_hit),
    .ecc_lo_in(ecc_lo_in), .ecc_hi_in(ecc_hi_in), .cmd_par_in(cmd_par_in),
    .ecc_lo_out(ecc_lo_out), .ecc_hi_out(ecc_hi_out), .cmd_par_out(cmd_par_out)
  );

  int vectors = 0;
  int fails = 0;
  string tag = "R1";
  logic [W-1:0] m_mask = '0;
  logic [4:0]   m_ctrl = '0;

  task automatic check_now();
    logic ev;
    logic [W-1:0] e_lo, e_hi, e_rd;
    logic e_par;
    ev    = xfer_valid & addr_hit;
    e_lo  = ecc_lo_in ^ ((ev && m_ctrl[3] && m_ctrl[1]) ? m_mask : '0);
    e_hi  = ecc_hi_in ^ ((ev && m_ctrl[3] && m_ctrl[2]) ? m_mask : '0);
    e_par = cmd_par_in ^ (ev & m_ctrl[4]);
    e_rd  = reg_rsel ? {27'd0, m_ctrl} : m_mask;
    vectors++;
    if (ecc_lo_out !== e_lo || ecc_hi_out !== e_hi || cmd_par_out !== e_par || reg_rdata !== e_rd) begin
      fails++;
      $display("FAIL %s: lo=%h/%h hi=%h/%h par=%b/%b rd=%h/%h (actual/expected)", tag,
               ecc_lo_out, e_lo, ecc_hi_out, e_hi, cmd_par_out, e_par, reg_rdata, e_rd);
    end
  endtask

  task automatic step();
    logic ev;
    #1 check_now();
    ev = xfer_valid & addr_hit;
    @(posedge clk);
    if (rst_n) begin
      if (ev && !m_ctrl[0]) m_ctrl[4:3] = 2'b00;
      if (reg_wr && reg_sel) m_ctrl = reg_wdata[4:0];
      if (reg_wr && !reg_sel) m_mask = reg_wdata;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    reg_wr = 0; xfer_valid = 0; addr_hit = 0;
  endtask

  task automatic wr(input logic sel, input logic [W-1:0] d);
    idle(); reg_wr = 1; reg_sel = sel; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic xfer(input logic v, input logic h, input logic [W-1:0] lo,
                      input logic [W-1:0] hi, input logic p, input logic rs);
    reg_wr = 0; xfer_valid = v; addr_hit = h;
    ecc_lo_in = lo; ecc_hi_in = hi; cmd_par_in = p; reg_rsel = rs; step();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tag = "R1";
    @(negedge clk); reg_rsel = 0; #1 check_now();
    reg_rsel = 1; #1 check_now();
    @(negedge clk); rst_n = 1; @(negedge clk);
    xfer(1, 1, 32'h1234_5678, 32'h9abc_def0, 1, 1);

    tag = "R2";
    wr(0, 32'hdead_beef);
    xfer(0, 0, '0, '0, 0, 0);
    xfer(0, 0, '0, '0, 0, 1);
    wr(1, 32'hffff_ffe0);
    xfer(0, 0, '0, '0, 0, 1);
    xfer(0, 0, '0, '0, 0, 0);

    tag = "R4";
    wr(1, 32'h0000_0007);
    xfer(1, 1, 32'haaaa_5555, 32'h0f0f_f0f0, 0, 1);
    wr(1, 32'h0000_000e);
    xfer(1, 0, 32'haaaa_5555, 32'h0f0f_f0f0, 0, 1);
    xfer(0, 1, 32'haaaa_5555, 32'h0f0f_f0f0, 0, 1);

    tag = "R5";
    wr(0, 32'h0000_0001);
    for (int s = 0; s < 4; s++) begin
      wr(1, 32'h8 | (s << 1));
      xfer(1, 1, 32'h1111_1111, 32'h2222_2222, 0, 1);
      xfer(0, 0, '0, '0, 0, 1);
    end
    wr(0, 32'h0101_0000);
    wr(1, 32'h0000_000e);
    xfer(1, 1, 32'h0, 32'hffff_ffff, 0, 1);

    tag = "R6";
    wr(0, 32'h0000_ff00);
    wr(1, 32'h0000_0002);
    wr(1, 32'h0000_001a);
    xfer(1, 1, 32'h5555_5555, 32'h0, 1, 1);
    xfer(1, 1, 32'h5555_5555, 32'h0, 1, 1);
    xfer(0, 0, '0, '0, 0, 1);
    wr(1, 32'h0000_0008);
    xfer(1, 1, 32'h3, 32'h3, 0, 1);
    xfer(1, 1, 32'h3, 32'h3, 0, 1);

    tag = "R7";
    wr(1, 32'h0000_001f);
    for (int i = 0; i < 4; i++) xfer(1, 1, 32'h1 << i, 32'h1 << (i + 8), i[0], 1);
    wr(1, 32'h0000_001e);
    xfer(1, 1, 32'h7, 32'h7, 0, 1);
    xfer(1, 1, 32'h7, 32'h7, 0, 1);

    tag = "R8";
    wr(0, 32'hffff_ffff);
    wr(1, 32'h0000_0010);
    xfer(1, 1, 32'h0, 32'h0, 0, 1);
    xfer(1, 1, 32'h0, 32'h0, 1, 1);
    wr(1, 32'h0000_0017);
    xfer(1, 1, 32'h0, 32'h0, 1, 1);
    xfer(0, 1, 32'h0, 32'h0, 1, 1);

    tag = "R9";
    wr(1, 32'h0000_001e);
    reg_wr = 1; reg_sel = 1; reg_wdata = 32'h0000_001c;
    xfer_valid = 1; addr_hit = 1; reg_rsel = 1; step();
    reg_wr = 0;
    xfer(1, 1, 32'hcafe_0000, 32'h0000_cafe, 0, 1);
    xfer(0, 0, '0, '0, 0, 1);

    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      reg_wr     = ($urandom_range(0, 7) == 0);
      reg_sel    = $urandom_range(0, 1);
      reg_wdata  = reg_sel ? W'($urandom_range(0, 31)) : W'($urandom);
      reg_rsel   = $urandom_range(0, 1);
      xfer_valid = $urandom_range(0, 1);
      addr_hit   = $urandom_range(0, 1);
      ecc_lo_in  = W'($urandom);
      ecc_hi_in  = W'($urandom);
      cmd_par_in = $urandom_range(0, 1);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule